// File: doc/BRIEF.md
# Four-Rail Power-Up Sequencer

This block releases four power-good flags, one after another, once the monitored input supply sits inside its allowed voltage window. The analog front end delivers four digital threshold compares: above-high and below-low for the undervoltage sense, and the same pair for the overvoltage sense. The block turns these into two hysteretic monitors. The supply counts as inside the window when the undervoltage monitor reports good and the overvoltage monitor reports no fault.

All timing advances on a slow oscillator tick. After the window is first satisfied, a start-up interval runs before flag A is released. Each of the gaps A→B, B→C and C→D lasts a fixed 255 full oscillator cycles, which is 510 half-periods. The length of one half-period, counted in ticks, is programmed separately for each gap.

A supply leaving the window pulls every flag low at once, and a new sequence begins as soon as the window is satisfied again. The same happens after the sequence has completed. A lockout input holds everything off while the supply rail is not yet trustworthy. Each flag is modelled as an open-drain pin through a pull-low enable.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: Synchronous active-low reset. After reset all four `pg_pull_low` bits are 1 and `seq_done` is 0. The undervoltage monitor reads "not good" and the overvoltage monitor reads "fault", so no sequence runs until the window is confirmed.
- R2: Undervoltage monitor. It turns good at an edge where `uv_above_hi`=1 and turns not-good at an edge where `uv_below_lo`=1; if both are 1, not-good wins. With both at 0 it keeps its previous state.
- R3: Overvoltage monitor. It turns to fault at an edge where `ov_above_hi`=1 and clears at an edge where `ov_below_lo`=1; if both are 1, fault wins. With both at 0 it keeps its previous state. The window is satisfied when the undervoltage monitor is good and the overvoltage monitor has no fault, both judged on the values they take at that edge.
- R4: A sequence starts at the first edge where the window is satisfied. Flag A activates at the edge where the `ramp_ticks`-th tick after the start edge is counted. A value of 0 acts as 1.
- R5: Each of flags B, C and D activates 2×255 = 510 half-periods after the edge at which the previous flag activated. One half-period lasts the programmed number of ticks for that gap (`gap_b_half`, `gap_c_half`, `gap_d_half`), with 0 acting as 1. So each gap is 510×N ticks.
- R6: Flags activate strictly in the order A, B, C, D. A flag is never active while its predecessor is inactive, and at most one flag activates at any edge.
- R7: At an edge where the window is not satisfied (for example `uv_below_lo`=1 or `ov_above_hi`=1), all flags become inactive and `seq_done` clears, whether the sequence was running or complete. A new sequence starts from the start-up interval at the first edge where the window is satisfied again.
- R8: While `lockout`=1, all flags are held inactive and no timing runs. Lockout also forces the monitors to their reset readings, so after release a full sequence runs once the window is confirmed.
- R9: Bit 0 of `pg_pull_low` is flag A, bit 1 is B, bit 2 is C and bit 3 is D. A bit is 1 (pin pulled low) while its flag is inactive and 0 (pin released) while its flag is active.
- R10: `seq_done` rises at the same edge at which flag D activates and clears together with the flags.
- R11: The start-up and gap values are captured at the edge where a sequence starts. Changing them during a sequence does not affect that sequence.
- R12: Timing advances only at edges where `osc_tick`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lockout | input | 1 | Supply lockout or power-on reset active; holds all flags off |
| uv_above_hi | input | 1 | Undervoltage sense is above its high threshold |
| uv_below_lo | input | 1 | Undervoltage sense is below its low threshold |
| ov_above_hi | input | 1 | Overvoltage sense is above its high threshold |
| ov_below_lo | input | 1 | Overvoltage sense is below its low threshold |
| osc_tick | input | 1 | One-cycle pulse from the slow oscillator |
| ramp_ticks | input | TIME_W | Start-up interval in ticks |
| gap_b_half | input | TIME_W | Half-period length in ticks for the A→B gap |
| gap_c_half | input | TIME_W | Half-period length in ticks for the B→C gap |
| gap_d_half | input | TIME_W | Half-period length in ticks for the C→D gap |
| pg_pull_low | output | 4 | Pull-low enable per flag; 1 means the flag is inactive |
| seq_done | output | 1 | Sequence complete (flag D active) |

## Verification
The assertions check on every cycle the properties that hold at all times:
- flag order, and no more than one new flag per edge;
- all flags pulled low on the edge after a below-low undervoltage or above-high overvoltage compare;
- all flags pulled low after a lockout cycle;
- `seq_done` rising exactly with flag D.

Only the bench's scenarios can show the properties that depend on timing and history:
- the exact edge of each release (start-up ticks, and 510 half-periods for each gap);
- hysteresis holding a state while the input sits between thresholds;
- the sequence restarting after recovery;
- programmed values being captured at start;
- timing pausing while no tick arrives.

// File: rtl/pwr_seq_pkg.sv
// Shared types for the power-up sequencer.
// Assumes the state order below: flag activity is decoded by comparing
// against this order, so the gap states must stay consecutive.
package pwr_seq_pkg;

    localparam int unsigned NUM_FLAGS = 4;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RAMP  = 3'd1,
        ST_GAP_B = 3'd2,
        ST_GAP_C = 3'd3,
        ST_GAP_D = 3'd4,
        ST_DONE  = 3'd5
    } seq_state_t;

    typedef enum logic {
        TM_SINGLE = 1'b0,
        TM_OSC    = 1'b1
    } tmr_mode_t;

endpackage

// File: rtl/pwr_seq_hyst.sv
// Hysteretic monitor built on two digital threshold compares.
// set_in raises the level and clr_in lowers it; SET_DOMINANT picks which
// one wins if both are asserted. force_off (and reset) drive the level to
// FORCE_VAL. level_c is the value the register takes at the coming edge,
// so a consumer can act in the same cycle as the compare.
module pwr_seq_hyst #(
    parameter bit SET_DOMINANT = 1'b0,
    parameter bit FORCE_VAL    = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_off,
    input  logic set_in,
    input  logic clr_in,
    output logic level_c
);

    logic level_q;
    logic raw_c;

    // Pick the compare priority according to the variant
    generate
        if (SET_DOMINANT) begin : g_set_wins
            always_comb raw_c = set_in ? 1'b1 : (clr_in ? 1'b0 : level_q);
        end else begin : g_clr_wins
            always_comb raw_c = clr_in ? 1'b0 : (set_in ? 1'b1 : level_q);
        end
    endgenerate

    // Forced value overrides the compares
    always_comb level_c = force_off ? FORCE_VAL : raw_c;

    // Hold the monitor level between edges
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= FORCE_VAL;
        else        level_q <= level_c;
    end

endmodule

// File: rtl/pwr_seq_timer.sv
// Tick-driven interval timer shared by the start-up interval and the gaps.
// TM_SINGLE: done after len ticks (one half-period).
// TM_OSC: done after 2*OSC_CYCLES half-periods of len ticks each.
// A len of 0 acts as 1. load restarts the timer and captures len and mode,
// and takes precedence over counting. done is a pulse valid in the cycle
// before the edge at which the interval ends.
module pwr_seq_timer
    import pwr_seq_pkg::*;
#(
    parameter int unsigned TIME_W     = 16,
    parameter int unsigned OSC_CYCLES = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  tmr_mode_t         mode,
    input  logic [TIME_W-1:0] len,
    input  logic              run,
    input  logic              tick,
    output logic              done
);

    localparam int unsigned CYC_W = (OSC_CYCLES > 1) ? $clog2(OSC_CYCLES) : 1;
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(OSC_CYCLES - 1);

    logic [TIME_W-1:0] len_q;
    logic [TIME_W-1:0] pre_q;
    logic [CYC_W-1:0]  cyc_q;
    logic              phase_q;
    tmr_mode_t         mode_q;
    logic [TIME_W-1:0] last_pre;
    logic              half_end;

    // End of one half-period: the tick that completes len ticks
    always_comb begin
        last_pre = (len_q == '0) ? '0 : len_q - 1'b1;
        half_end = run && tick && (pre_q == last_pre);
        done     = half_end &&
                   ((mode_q == TM_SINGLE) || (phase_q && (cyc_q == CYC_LAST)));
    end

    // Tick prescaler, half-period phase and full-cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q   <= '0;
            pre_q   <= '0;
            cyc_q   <= '0;
            phase_q <= 1'b0;
            mode_q  <= TM_SINGLE;
        end else if (load) begin
            len_q   <= len;
            mode_q  <= mode;
            pre_q   <= '0;
            cyc_q   <= '0;
            phase_q <= 1'b0;
        end else if (half_end) begin
            pre_q   <= '0;
            phase_q <= ~phase_q;
            if (phase_q) cyc_q <= cyc_q + 1'b1;
        end else if (run && tick) begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwr_seq_ctrl.sv
// Four-flag power-up sequencer, top level.
// Two hysteretic monitors judge the supply window, and one FSM walks
// start-up -> gap B -> gap C -> gap D -> done, using a shared timer.
// Any edge with the window unsatisfied (or lockout) returns to idle and
// pulls all flags low. Programmed values are captured at the start edge.
// Assumes osc_tick is a single-cycle pulse synchronous to clk.
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int unsigned TIME_W     = 16,
    parameter int unsigned OSC_CYCLES = 255
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lockout,
    input  logic                 uv_above_hi,
    input  logic                 uv_below_lo,
    input  logic                 ov_above_hi,
    input  logic                 ov_below_lo,
    input  logic                 osc_tick,
    input  logic [TIME_W-1:0]    ramp_ticks,
    input  logic [TIME_W-1:0]    gap_b_half,
    input  logic [TIME_W-1:0]    gap_c_half,
    input  logic [TIME_W-1:0]    gap_d_half,
    output logic [NUM_FLAGS-1:0] pg_pull_low,
    output logic                 seq_done
);

    localparam int unsigned NUM_GAPS = NUM_FLAGS - 1;

    seq_state_t        state_q, state_d;
    logic              uv_good_c, ov_fault_c, win_ok_c;
    logic              tmr_load, tmr_run, tmr_done;
    tmr_mode_t         tmr_mode;
    logic [TIME_W-1:0] tmr_len;
    logic [TIME_W-1:0] gap_in [NUM_GAPS];
    logic [TIME_W-1:0] gap_q  [NUM_GAPS];
    logic              start_go;
    logic [NUM_FLAGS-1:0] flag_act;

    // Undervoltage: low compare wins, lockout forces "not good"
    pwr_seq_hyst #(.SET_DOMINANT(1'b0), .FORCE_VAL(1'b0)) u_uv (
        .clk      (clk),
        .rst_n    (rst_n),
        .force_off(lockout),
        .set_in   (uv_above_hi),
        .clr_in   (uv_below_lo),
        .level_c  (uv_good_c)
    );

    // Overvoltage: high compare wins, lockout forces "fault"
    pwr_seq_hyst #(.SET_DOMINANT(1'b1), .FORCE_VAL(1'b1)) u_ov (
        .clk      (clk),
        .rst_n    (rst_n),
        .force_off(lockout),
        .set_in   (ov_above_hi),
        .clr_in   (ov_below_lo),
        .level_c  (ov_fault_c)
    );

    // Window decision uses the monitor values of the coming edge
    always_comb win_ok_c = uv_good_c && !ov_fault_c;

    // Gather programmed gap lengths in flag order
    always_comb begin
        gap_in[0] = gap_b_half;
        gap_in[1] = gap_c_half;
        gap_in[2] = gap_d_half;
    end

    // Sequence start condition
    always_comb start_go = (state_q == ST_IDLE) && win_ok_c;

    // Capture gap lengths when a sequence starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_GAPS; i++) gap_q[i] <= '0;
        end else if (start_go) begin
            for (int i = 0; i < NUM_GAPS; i++) gap_q[i] <= gap_in[i];
        end
    end

    // Next state and timer load selection
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_mode = TM_OSC;
        tmr_len  = '0;
        if (!win_ok_c) begin
            state_d = ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    state_d  = ST_RAMP;
                    tmr_load = 1'b1;
                    tmr_mode = TM_SINGLE;
                    tmr_len  = ramp_ticks;
                end
                ST_RAMP: if (tmr_done) begin
                    state_d  = ST_GAP_B;
                    tmr_load = 1'b1;
                    tmr_len  = gap_q[0];
                end
                ST_GAP_B: if (tmr_done) begin
                    state_d  = ST_GAP_C;
                    tmr_load = 1'b1;
                    tmr_len  = gap_q[1];
                end
                ST_GAP_C: if (tmr_done) begin
                    state_d  = ST_GAP_D;
                    tmr_load = 1'b1;
                    tmr_len  = gap_q[2];
                end
                ST_GAP_D: if (tmr_done) state_d = ST_DONE;
                default:  state_d = state_q;
            endcase
        end
    end

    // Timer runs only while an interval is pending
    always_comb tmr_run = (state_q != ST_IDLE) && (state_q != ST_DONE);

    // Sequencer state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    pwr_seq_timer #(.TIME_W(TIME_W), .OSC_CYCLES(OSC_CYCLES)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmr_load),
        .mode (tmr_mode),
        .len  (tmr_len),
        .run  (tmr_run),
        .tick (osc_tick),
        .done (tmr_done)
    );

    // Flag n is active once the state has passed the interval before it
    generate
        for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
            assign flag_act[g]    = (state_q >= seq_state_t'(ST_GAP_B + g));
            assign pg_pull_low[g] = ~flag_act[g];
        end
    endgenerate

    // Completion status
    always_comb seq_done = (state_q == ST_DONE);

endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
// Property checker for pwr_seq_ctrl, attached through bind.
// It observes only the top-level ports.
module pwr_seq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lockout,
    input logic       uv_below_lo,
    input logic       ov_above_hi,
    input logic [3:0] pg_pull_low,
    input logic       seq_done
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (pg_pull_low == 4'hF && !seq_done));

    // R6
    flag_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~pg_pull_low[3:1]) & pg_pull_low[2:0]) == 3'b000);

    // R6
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones((~pg_pull_low) & $past(pg_pull_low)) <= 1);

    // R7
    fault_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_below_lo || ov_above_hi) |=> (pg_pull_low == 4'hF && !seq_done));

    // R8
    lockout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |=> (pg_pull_low == 4'hF && !seq_done));

    // R10
    done_with_d_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_done) |-> $fell(pg_pull_low[3]));

    // R10
    done_all_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (pg_pull_low == 4'h0));

endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lockout    (lockout),
    .uv_below_lo(uv_below_lo),
    .ov_above_hi(ov_above_hi),
    .pg_pull_low(pg_pull_low),
    .seq_done   (seq_done)
);

// File: tb/sim_pwr_seq_ctrl.sv
// Directed bench for pwr_seq_ctrl. Inputs change and outputs are sampled
// on the falling edge. Each check compares {seq_done, pg_pull_low}.
module sim_pwr_seq_ctrl;

    localparam int unsigned TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lockout = 1'b0;
    logic          uv_above_hi = 1'b0;
    logic          uv_below_lo = 1'b1;
    logic          ov_above_hi = 1'b0;
    logic          ov_below_lo = 1'b1;
    logic          osc_tick = 1'b1;
    logic [TW-1:0] ramp_ticks = 16'd5;
    logic [TW-1:0] gap_b_half = 16'd1;
    logic [TW-1:0] gap_c_half = 16'd2;
    logic [TW-1:0] gap_d_half = 16'd1;
    logic [3:0]    pg_pull_low;
    logic          seq_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pwr_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .lockout(lockout),
        .uv_above_hi(uv_above_hi), .uv_below_lo(uv_below_lo),
        .ov_above_hi(ov_above_hi), .ov_below_lo(ov_below_lo),
        .osc_tick(osc_tick), .ramp_ticks(ramp_ticks),
        .gap_b_half(gap_b_half), .gap_c_half(gap_c_half),
        .gap_d_half(gap_d_half), .pg_pull_low(pg_pull_low),
        .seq_done(seq_done)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [4:0] exp);
        checks++;
        if ({seq_done, pg_pull_low} !== exp) begin
            fails++;
            $display("FAIL %s: {done,pull_low} actual=%b expected=%b",
                     req, {seq_done, pg_pull_low}, exp);
        end
    endtask

    // R1: reset state, and no start while the window is unconfirmed
    task automatic t_reset();
        step(3);
        chk("R1 in reset", 5'b0_1111);
        rst_n = 1'b1;
        step(10);
        chk("R1 idle after reset", 5'b0_1111);
    endtask

    // R4 R5 R9 R10 R2: full sequence with the boundary edges checked
    task automatic t_sequence();
        uv_above_hi = 1'b1; uv_below_lo = 1'b0;
        step(1);
        uv_above_hi = 1'b0;            // between thresholds: must stay good
        step(4);
        chk("R4 A not yet", 5'b0_1111);
        step(1);
        chk("R4 R9 A released", 5'b0_1110);
        step(509);
        chk("R5 B not yet", 5'b0_1110);
        step(1);
        chk("R5 B released", 5'b0_1100);
        step(1019);
        chk("R5 C not yet", 5'b0_1100);
        step(1);
        chk("R5 C released", 5'b0_1000);
        step(509);
        chk("R10 D and done not yet", 5'b0_1000);
        step(1);
        chk("R10 R2 D with done", 5'b1_0000);
    endtask

    // R7 R2: undervoltage after completion, hysteresis hold, restart
    task automatic t_fault_done();
        uv_below_lo = 1'b1;
        step(1);
        chk("R7 drop after done", 5'b0_1111);
        step(5);
        uv_below_lo = 1'b0;
        step(10);
        chk("R2 stays bad between thresholds", 5'b0_1111);
        uv_above_hi = 1'b1;
        step(1);
        uv_above_hi = 1'b0;
        step(4);
        chk("R7 restart A not yet", 5'b0_1111);
        step(1);
        chk("R7 restart A released", 5'b0_1110);
    endtask

    // R3 R7: overvoltage mid-sequence, hysteresis hold, recovery
    task automatic t_ov();
        step(100);
        chk("R7 still in gap", 5'b0_1110);
        ov_above_hi = 1'b1; ov_below_lo = 1'b0;
        step(1);
        chk("R7 drop on overvoltage", 5'b0_1111);
        ov_above_hi = 1'b0;
        step(10);
        chk("R3 fault held between thresholds", 5'b0_1111);
        ov_below_lo = 1'b1;
        step(5);
        chk("R3 restart A not yet", 5'b0_1111);
        step(1);
        chk("R3 restart A released", 5'b0_1110);
    endtask

    // R11: changes during a running sequence are ignored
    task automatic t_sample();
        gap_b_half = 16'd3;
        ramp_ticks = 16'd50;
        step(509);
        chk("R11 B not yet", 5'b0_1110);
        step(1);
        chk("R11 B at captured length", 5'b0_1100);
        gap_b_half = 16'd1;
        ramp_ticks = 16'd5;
    endtask

    // R8 R12: lockout hold, then a start-up interval paused by missing ticks
    task automatic t_lock_tick();
        lockout = 1'b1;
        step(1);
        chk("R8 drop on lockout", 5'b0_1111);
        uv_above_hi = 1'b1;
        step(50);
        chk("R8 held during lockout", 5'b0_1111);
        lockout = 1'b0;
        step(2);
        osc_tick = 1'b0;
        step(20);
        chk("R12 no progress without tick", 5'b0_1111);
        osc_tick = 1'b1;
        step(3);
        chk("R12 A not yet", 5'b0_1111);
        step(1);
        chk("R8 R12 A released", 5'b0_1110);
    endtask

    initial begin
        t_reset();
        t_sequence();
        t_fault_done();
        t_ov();
        t_sample();
        t_lock_tick();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule